// File: doc/BRIEF.md
# Floating-point compare unit

This block is the compare stage of a scalar floating-point unit. On an issue strobe it takes two 64-bit IEEE-754 double-precision operands and works out how they relate. The result is a 4-bit relation code. The block writes that code into one selectable 4-bit field of a 32-bit condition register. It also places the code in the compare-code bits of a 32-bit floating-point status register. Both registers are held inside the block and are visible on its outputs.

There are two compare flavours, chosen by a 10-bit sub-opcode. The unordered flavour completes normally when either operand is a NaN and reports "unordered". The ordered flavour refuses to complete on a NaN. It raises an invalid-operand trap strobe and records the event in a sticky status bit. A malformed field index or an unknown sub-opcode raises an illegal-instruction strobe and changes nothing. Operand register-file reads and exception vectoring belong to the surrounding pipeline.

Top module: `fcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), a completed compare yields the unordered code 4'b0001.
- R2: With no NaN operand the code is exactly one of less-than 4'b1000, greater-than 4'b0100 or equal 4'b0010 (code bit 3 = a<b, bit 2 = a>b, bit 1 = equal, bit 0 = unordered). Positive and negative zero compare equal, and infinities compare by sign.
- R3: A field index whose two low bits are not both zero is illegal. It pulses `illegal_o` and leaves `cr_o`, `fsr_o` and `code_o` unchanged.
- R4: On completion, field k = index>>2 of `cr_o` (bits 31-4k down to 28-4k, so field 0 is bits 31:28) takes the code, and the other seven fields keep their values.
- R5: Sub-opcode 0 selects the unordered flavour and 32 selects the ordered flavour. Any other value pulses `illegal_o` with no register change. Illegal takes priority over a trap.
- R6: An ordered compare with a NaN operand pulses `trap_o` and sets sticky bit 19 of `fsr_o`. It leaves `cr_o`, `code_o` and the other status bits unchanged.
- R7: On completion `fsr_o` bit 15 is cleared and the code is placed in bits 14:11. All other status bits keep their values.
- R8: The outcome appears exactly one clock after the issue strobe. Exactly one of `done_o`, `illegal_o` and `trap_o` pulses for one cycle, and `code_o` is updated with `done_o`. After reset every output is zero.
- R9: Without an issue strobe, no output changes, whatever the operand and control inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One-cycle strobe starting a compare |
| op_a_i | input | 64 | First double-precision operand |
| op_b_i | input | 64 | Second double-precision operand |
| field_idx_i | input | 5 | Destination condition-field index (low two bits must be zero) |
| subop_i | input | 10 | Sub-opcode: 0 unordered, 32 ordered |
| code_o | output | 4 | Relation code of the last completed compare |
| cr_o | output | 32 | Condition register |
| fsr_o | output | 32 | Floating-point status register |
| done_o | output | 1 | Compare completed and registers written |
| illegal_o | output | 1 | Illegal-instruction strobe |
| trap_o | output | 1 | Invalid-operand trap strobe |

## Verification
The assertions assume that `issue_i` is a single-cycle strobe. They also assume that the operands, index and sub-opcode are stable around the clock edge that samples the strobe. Under these assumptions the one-cycle outcome relation and the "no change on illegal or trap" checks refer to a single well-defined compare. The stimulus drives every input on the falling edge and holds the strobe high for exactly one cycle. Between compares it wiggles the operand and control inputs with the strobe low. This shows that idle cycles leave the registers untouched.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_LT = 4'b1000;
    localparam logic [CODE_W-1:0] CODE_GT = 4'b0100;
    localparam logic [CODE_W-1:0] CODE_EQ = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_UN = 4'b0001;

    typedef struct packed {
        logic [31:0]       cr;
        logic [31:0]       fsr;
        logic [CODE_W-1:0] code;
        logic              done;
        logic              illegal;
        logic              trap;
    } fcmp_state_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DW    = 1 + EXP_W + FRAC_W
) (
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    output logic [CODE_W-1:0] code_o,
    output logic              nan_o
);

    localparam int MAG_W = DW - 1;

    logic              a_nan, b_nan, both_zero, a_sign, b_sign, mag_gt, same;
    logic [MAG_W-1:0]  a_mag, b_mag;

    assign a_sign    = a_i[DW-1];
    assign b_sign    = b_i[DW-1];
    assign a_mag     = a_i[MAG_W-1:0];
    assign b_mag     = b_i[MAG_W-1:0];
    assign a_nan     = (&a_i[DW-2 -: EXP_W]) && (|a_i[FRAC_W-1:0]);
    assign b_nan     = (&b_i[DW-2 -: EXP_W]) && (|b_i[FRAC_W-1:0]);
    assign both_zero = (a_mag == '0) && (b_mag == '0);
    assign mag_gt    = a_mag > b_mag;
    assign same      = a_i == b_i;
    assign nan_o     = a_nan || b_nan;

    always_comb begin
        if (nan_o) begin
            code_o = CODE_UN;
        end else if (both_zero || same) begin
            code_o = CODE_EQ;
        end else if (a_sign != b_sign) begin
            code_o = a_sign ? CODE_LT : CODE_GT;
        end else if (a_sign) begin
            code_o = mag_gt ? CODE_LT : CODE_GT;
        end else begin
            code_o = mag_gt ? CODE_GT : CODE_LT;
        end
    end

endmodule

// File: rtl/fcmp_decode.sv
module fcmp_decode #(
    parameter int IDX_W       = 5,
    parameter int SUBOP_W     = 10,
    parameter int SUBOP_UNORD = 0,
    parameter int SUBOP_ORD   = 32,
    localparam int SEL_W      = IDX_W - 2
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [SUBOP_W-1:0] subop_i,
    output logic               illegal_o,
    output logic               ordered_o,
    output logic [SEL_W-1:0]   field_o
);

    logic is_unord, is_ord;

    assign is_unord  = subop_i == SUBOP_W'(SUBOP_UNORD);
    assign is_ord    = subop_i == SUBOP_W'(SUBOP_ORD);
    assign ordered_o = is_ord;
    assign field_o   = idx_i[IDX_W-1:2];
    assign illegal_o = (|idx_i[1:0]) || !(is_unord || is_ord);

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W      = 11,
    parameter int FRAC_W     = 52,
    parameter int IDX_W      = 5,
    parameter int SUBOP_W    = 10,
    parameter int CC_LO      = 11,
    parameter int STICKY_BIT = 19,
    localparam int DW        = 1 + EXP_W + FRAC_W,
    localparam int REG_W     = 32,
    localparam int NFIELD    = REG_W / CODE_W,
    localparam int SEL_W     = IDX_W - 2,
    localparam int CC_TOP    = CC_LO + CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [DW-1:0]      op_a_i,
    input  logic [DW-1:0]      op_b_i,
    input  logic [IDX_W-1:0]   field_idx_i,
    input  logic [SUBOP_W-1:0] subop_i,
    output logic [CODE_W-1:0]  code_o,
    output logic [REG_W-1:0]   cr_o,
    output logic [REG_W-1:0]   fsr_o,
    output logic               done_o,
    output logic               illegal_o,
    output logic               trap_o
);

    fcmp_state_t st_d, st_q;

    logic [CODE_W-1:0] cmp_code;
    logic              cmp_nan, dec_illegal, dec_ordered;
    logic [SEL_W-1:0]  dec_field;

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .code_o (cmp_code),
        .nan_o  (cmp_nan)
    );

    fcmp_decode #(.IDX_W(IDX_W), .SUBOP_W(SUBOP_W)) u_decode (
        .idx_i     (field_idx_i),
        .subop_i   (subop_i),
        .illegal_o (dec_illegal),
        .ordered_o (dec_ordered),
        .field_o   (dec_field)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        st_d.trap    = 1'b0;
        if (issue_i) begin
            if (dec_illegal) begin
                st_d.illegal = 1'b1;
            end else if (dec_ordered && cmp_nan) begin
                st_d.trap                = 1'b1;
                st_d.fsr[STICKY_BIT]     = 1'b1;
            end else begin
                st_d.done = 1'b1;
                st_d.code = cmp_code;
                for (int k = 0; k < NFIELD; k++) begin
                    if (dec_field == SEL_W'(k)) begin
                        st_d.cr[REG_W-1-k*CODE_W -: CODE_W] = cmp_code;
                    end
                end
                st_d.fsr[CC_TOP]            = 1'b0;
                st_d.fsr[CC_TOP-1 -: CODE_W] = cmp_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o    = st_q.code;
    assign cr_o      = st_q.cr;
    assign fsr_o     = st_q.fsr;
    assign done_o    = st_q.done;
    assign illegal_o = st_q.illegal;
    assign trap_o    = st_q.trap;

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, illegal_o, trap_o}));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> (done_o || illegal_o || trap_o));

    assert_code_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones(code_o) == 1);

    assert_illegal_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($stable(cr_o) && $stable(fsr_o) && $stable(code_o)));

    assert_trap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (fsr_o[STICKY_BIT] && $stable(cr_o) && $stable(code_o)));

    assert_fsr_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!fsr_o[CC_TOP] && fsr_o[CC_TOP-1 -: CODE_W] == code_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ($stable(cr_o) && $stable(fsr_o) && $stable(code_o)));

endmodule

// File: tb/sim_fcmp_unit.sv
`timescale 1ns/1ps
module sim_fcmp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [63:0] a = '0, b = '0;
    logic [4:0]  idx = '0;
    logic [9:0]  subop = '0;
    logic [3:0]  code;
    logic [31:0] cr, fsr;
    logic        done, illegal, trap;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_cr = '0, m_fsr = '0;
    logic [3:0]  m_code = '0;

    localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN   = 64'hFFF0_0000_0000_0001;
    localparam logic [63:0] TINY   = 64'h0000_0000_0000_0001;

    always #5 clk = ~clk;

    fcmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_a_i(a), .op_b_i(b),
        .field_idx_i(idx), .subop_i(subop), .code_o(code), .cr_o(cr),
        .fsr_o(fsr), .done_o(done), .illegal_o(illegal), .trap_o(trap)
    );

    function automatic bit is_nan(logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    function automatic logic [3:0] ref_code(logic [63:0] x, logic [63:0] y);
        real rx, ry;
        if (is_nan(x) || is_nan(y)) return 4'b0001;
        rx = $bitstoreal(x);
        ry = $bitstoreal(y);
        if (rx == ry) return 4'b0010;
        if (rx < ry)  return 4'b1000;
        return 4'b0100;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_cmp(string tag, logic [63:0] x, logic [63:0] y,
                           logic [4:0] fi, logic [9:0] so);
        bit e_ill, e_trap, e_done;
        logic [3:0] c;
        e_ill  = (fi[1:0] != 0) || (so != 0 && so != 32);
        e_trap = !e_ill && so == 32 && (is_nan(x) || is_nan(y));
        e_done = !e_ill && !e_trap;
        c = ref_code(x, y);
        if (e_trap) m_fsr[19] = 1'b1;
        if (e_done) begin
            m_code = c;
            m_cr[31 - 4*fi[4:2] -: 4] = c;
            m_fsr[15] = 1'b0;
            m_fsr[14:11] = c;
        end
        @(negedge clk);
        a = x; b = y; idx = fi; subop = so; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check({tag, " done"},    done,    e_done);
        check({tag, " illegal"}, illegal, e_ill);
        check({tag, " trap"},    trap,    e_trap);
        check({tag, " code"},    code,    m_code);
        check({tag, " cr"},      cr,      m_cr);
        check({tag, " fsr"},     fsr,     m_fsr);
        @(negedge clk);
        check({tag, " pulse R8"}, {done, illegal, trap}, 3'b000);
    endtask

    task automatic t_reset;
        check("R8 reset cr", cr, 0);
        check("R8 reset fsr", fsr, 0);
        check("R8 reset code", code, 0);
        check("R8 reset strobes", {done, illegal, trap}, 0);
    endtask

    task automatic t_relations;
        run_cmp("R2 lt", P_ONE, P_TWO, 5'd0, 10'd0);
        run_cmp("R2 gt", P_TWO, P_ONE, 5'd4, 10'd0);
        run_cmp("R2 eq", N_TWO, N_TWO, 5'd8, 10'd32);
        run_cmp("R2 neg lt", N_TWO, N_ONE, 5'd12, 10'd0);
        run_cmp("R2 sign gt", P_ONE, N_TWO, 5'd16, 10'd32);
        run_cmp("R2 zeros eq", P_ZERO, N_ZERO, 5'd20, 10'd0);
        run_cmp("R2 inf lt", N_INF, P_INF, 5'd24, 10'd32);
        run_cmp("R2 tiny gt", TINY, N_ZERO, 5'd28, 10'd0);
    endtask

    task automatic t_fields;
        for (int k = 0; k < 8; k++) begin
            run_cmp("R4 field", (k % 2 == 0) ? P_ONE : P_TWO, P_TWO, 5'(4*k), 10'd0);
        end
    endtask

    task automatic t_nan_unordered;
        run_cmp("R1 qnan a", QNAN, P_ONE, 5'd8, 10'd0);
        run_cmp("R1 snan b", P_ONE, SNAN, 5'd0, 10'd0);
        run_cmp("R7 fsr after unordered", P_INF, P_INF, 5'd4, 10'd0);
    endtask

    task automatic t_nan_ordered;
        run_cmp("R6 trap", QNAN, P_ONE, 5'd12, 10'd32);
        run_cmp("R6 trap b", P_ZERO, SNAN, 5'd0, 10'd32);
        run_cmp("R7 after trap", N_ONE, P_ONE, 5'd0, 10'd32);
    endtask

    task automatic t_illegal;
        run_cmp("R3 idx low", P_ONE, P_TWO, 5'd1, 10'd0);
        run_cmp("R3 idx low2", P_TWO, P_ONE, 5'd6, 10'd32);
        run_cmp("R5 subop", P_ONE, P_TWO, 5'd0, 10'd1);
        run_cmp("R5 subop hi", P_ONE, P_TWO, 5'd4, 10'd64);
        run_cmp("R5 illegal over trap", QNAN, P_ONE, 5'd3, 10'd32);
    endtask

    task automatic t_idle;
        @(negedge clk);
        a = N_INF; b = P_INF; idx = 5'd16; subop = 10'd0;
        repeat (3) @(negedge clk);
        a = QNAN; subop = 10'd32;
        @(negedge clk);
        check("R9 idle cr", cr, m_cr);
        check("R9 idle fsr", fsr, m_fsr);
        check("R9 idle code", code, m_code);
        check("R9 idle strobes", {done, illegal, trap}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_relations();
        t_fields();
        t_nan_unordered();
        t_nan_ordered();
        t_illegal();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule